// File: doc/BRIEF.md
# Command Packet Parser

This block decodes a single 64-byte command packet already sitting in a byte-addressed buffer, then walks the scatter-gather table that the packet points to. A one-cycle `start` strobe with the packet's base address launches it. The parser reads the buffer through a read port. The read port has no latency: the data answers the address in the same cycle. The parser first gathers the header bytes it needs and checks the two block tags, the valid flag, the entry count and the table address. If any of these checks fails, it finishes at once with a format error. If all pass, it presents the decoded control fields together with the address where the command FIS starts.

For each table entry in turn, the parser reads the 12 meaningful bytes and offers one address/length pair on a valid/ready handshake. It keeps a running sum of the lengths. After the last entry it ends with a one-cycle `done` pulse and a status code. The status reports a length error if the sum of the entry lengths differs from the packet's total byte count. Moving the data and sending the FIS are left to the blocks that consume these outputs.

Top module: `cpp_cmd_parser`

## Requirements
- R1: Once reset has been released, `busy`, `done`, `hdr_valid` and `xfer_valid` are all low.
- R2: `hdr_valid` pulses for one cycle after a good header. While it is high, `dir_out`, `is_data` and `irq_en` equal bits 0, 3 and 4 of packet byte 1, and `use_dma` and `lba48` equal bits 2 and 3 of packet byte 28. `byte_cnt` is bytes 4..7 read as a little-endian number, and `fis_addr` is `pkt_base + 32`.
- R3: Any of the following ends the run with status 2'b01 (format error), no `hdr_valid` and no transfer request:
  - byte 0 is not 0x01;
  - byte 24 is not 0x02;
  - bit 5 of byte 1 (packet valid) is clear.
- R4: An entry count of zero (bytes 8..11, little-endian) ends the run with status 2'b01 and no transfer request.
- R5: A table address (bytes 16..23, little-endian) with any bit set at or above `ADDR_W` ends the run with status 2'b01 and no transfer request.
- R6: Entry i sits at table address + 16*i. Each entry produces one request, and requests come out in table order:
  - `xfer_addr` is entry bytes 0..7, little-endian;
  - `xfer_len` is entry bytes 8..11, little-endian.
- R7: While `xfer_valid` is high and `xfer_ready` is low, the request stays pending, and `xfer_addr` and `xfer_len` hold steady.
- R8: After the last accepted request, the status is 2'b00 when the sum of the entry lengths equals `byte_cnt`, and 2'b10 otherwise.
- R9: A `start` that arrives while `busy` is high is ignored. It causes no second run and no extra `done`.
- R10: `done` is a single-cycle pulse raised with `busy` already low. `status` holds its value until the next run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin parsing the packet at `pkt_base` |
| pkt_base | input | ADDR_W | Byte address of the packet |
| rd_addr | output | ADDR_W | Buffer read address |
| rd_data | input | 8 | Buffer byte at `rd_addr`, same cycle |
| busy | output | 1 | A run is in progress |
| hdr_valid | output | 1 | Header accepted, decoded fields valid |
| dir_out | output | 1 | Data moves toward the device |
| is_data | output | 1 | Packet carries data |
| irq_en | output | 1 | Completion interrupt requested |
| use_dma | output | 1 | DMA rather than PIO |
| lba48 | output | 1 | 48-bit addressing |
| byte_cnt | output | 32 | Total transfer byte count |
| fis_addr | output | ADDR_W | Buffer address of the command FIS |
| xfer_valid | output | 1 | Transfer request pending |
| xfer_ready | input | 1 | Consumer accepts the request |
| xfer_addr | output | 64 | Segment address |
| xfer_len | output | 32 | Segment length in bytes |
| done | output | 1 | Run finished, `status` valid |
| status | output | 2 | 00 ok, 01 format error, 10 length error |

## Verification
The assertions assume two things about the inputs. First, `rd_data` always answers the current `rd_addr` in the same cycle. Second, the consumer never needs the request to disappear before it raises `xfer_ready`. The bench meets both: it serves `rd_data` from a continuous read of its own byte array, and it changes `xfer_ready` only on the falling edge. The bench places every packet and table inside that array, below the address width, except the one packet that deliberately sets a high table-address bit. Its ready pattern stalls one cycle out of three, so every run exercises the hold behaviour.

// File: rtl/cpp_pkg.sv
package cpp_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_HDR   = 3'd1,
    S_CHK   = 3'd2,
    S_SGRD  = 3'd3,
    S_SGOUT = 3'd4,
    S_FIN   = 3'd5
  } cpp_state_t;

  localparam logic [1:0] ST_OK  = 2'b00;
  localparam logic [1:0] ST_FMT = 2'b01;
  localparam logic [1:0] ST_LEN = 2'b10;

  localparam logic [7:0] HCB_TAG = 8'h01;
  localparam logic [7:0] DCB_TAG = 8'h02;

  localparam int HF_DIR   = 0;
  localparam int HF_DATA  = 3;
  localparam int HF_IRQ   = 4;
  localparam int HF_VALID = 5;
  localparam int DF_DMA   = 2;
  localparam int DF_LBA48 = 3;

  localparam int HDR_STEPS  = 20;
  localparam int ENT_BYTES  = 12;
  localparam int ENT_STRIDE = 16;
  localparam int FIS_OFS    = 32;

  // header read step -> packet byte offset
  function automatic logic [4:0] hdr_offset(input logic [4:0] s);
    if (s < 5'd2)       return s;
    else if (s < 5'd10) return s + 5'd2;
    else if (s < 5'd18) return s + 5'd6;
    else if (s == 5'd18) return 5'd24;
    else                return 5'd28;
  endfunction

endpackage

// File: rtl/cpp_rst_sync.sv
module cpp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cpp_le_accum.sv
module cpp_le_accum #(
  parameter int NBYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   wr_en,
  input  logic [IW-1:0]          wr_idx,
  input  logic [7:0]             wr_byte,
  output logic [8*NBYTES-1:0]    value
);
  localparam int IW = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [7:0] lane_q, lane_d;
    logic       lane_en;

    assign lane_en = clr || (wr_en && (wr_idx == IW'(g)));
    assign lane_d  = clr ? 8'h00 : wr_byte;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= 8'h00;
      else if (lane_en) lane_q <= lane_d;
    end

    assign value[8*g +: 8] = lane_q;
  end
endmodule

// File: rtl/cpp_len_tally.sv
module cpp_len_tally #(
  parameter int LEN_W = 32,
  parameter int SUM_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_en,
  input  logic [LEN_W-1:0] add_len,
  input  logic [LEN_W-1:0] total,
  output logic [SUM_W-1:0] sum,
  output logic             match
);
  logic [SUM_W-1:0] sum_q, sum_d;

  always_comb begin
    sum_d = sum_q;
    if (clr)         sum_d = '0;
    else if (add_en) sum_d = sum_q + SUM_W'(add_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  assign sum   = sum_q;
  assign match = (sum_q == SUM_W'(total));

  // R8: a new run always starts its tally from zero
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sum == '0));
endmodule

// File: rtl/cpp_hdr_check.sv
module cpp_hdr_check #(
  parameter int ADDR_W = 16
) (
  input  logic [7:0]  tag0,
  input  logic [7:0]  hflags,
  input  logic [7:0]  tag1,
  input  logic [31:0] nent,
  input  logic [63:0] tbl,
  output logic        fmt_err
);
  import cpp_pkg::*;

  logic bad_tags, bad_valid, bad_count, bad_range;

  assign bad_tags  = (tag0 != HCB_TAG) || (tag1 != DCB_TAG);
  assign bad_valid = !hflags[HF_VALID];
  assign bad_count = (nent == 32'd0);
  assign bad_range = |tbl[63:ADDR_W];
  assign fmt_err   = bad_tags || bad_valid || bad_count || bad_range;
endmodule

// File: rtl/cpp_cmd_parser.sv
module cpp_cmd_parser #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] pkt_base,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              busy,
  output logic              hdr_valid,
  output logic              dir_out,
  output logic              is_data,
  output logic              irq_en,
  output logic              use_dma,
  output logic              lba48,
  output logic [31:0]       byte_cnt,
  output logic [ADDR_W-1:0] fis_addr,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [63:0]       xfer_addr,
  output logic [31:0]       xfer_len,
  output logic              done,
  output logic [1:0]        status
);
  import cpp_pkg::*;

  localparam logic [4:0] HDR_LAST = 5'(HDR_STEPS - 1);
  localparam logic [4:0] ENT_LAST = 5'(ENT_BYTES - 1);

  logic rst_ni;

  cpp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_ni)
  );

  cpp_state_t        state_q, state_n;
  logic [4:0]        step_q, step_n;
  logic [ADDR_W-1:0] base_q, base_n;
  logic [ADDR_W-1:0] ent_q, ent_n;
  logic [31:0]       remain_q, remain_n;
  logic [7:0]        tag0_q, tag0_n, hflags_q, hflags_n;
  logic [7:0]        tag1_q, tag1_n, dflags_q, dflags_n;
  logic              fmt_q, fmt_n;
  logic              done_q, done_n;
  logic              hdrv_q, hdrv_n;
  logic [1:0]        status_q, status_n;

  logic              acc_clr, tally_add;
  logic              cnt_we, nent_we, tbl_we, sga_we, sgl_we;
  logic [4:0]        d_cnt, d_nent, d_tbl;
  logic [31:0]       cnt_val, nent_val, len_val;
  logic [63:0]       tbl_val, addr_val, tally_sum;
  logic              tally_match, fmt_err;

  // header and entry byte steering
  assign d_cnt  = step_q - 5'd2;
  assign d_nent = step_q - 5'd6;
  assign d_tbl  = step_q - 5'd10;

  always_comb begin
    cnt_we  = (state_q == S_HDR) && (step_q >= 5'd2)  && (step_q <= 5'd5);
    nent_we = (state_q == S_HDR) && (step_q >= 5'd6)  && (step_q <= 5'd9);
    tbl_we  = (state_q == S_HDR) && (step_q >= 5'd10) && (step_q <= 5'd17);
    sga_we  = (state_q == S_SGRD) && (step_q < 5'd8);
    sgl_we  = (state_q == S_SGRD) && (step_q >= 5'd8);
  end

  cpp_le_accum #(.NBYTES(4)) u_cnt (
    .clk(clk), .rst_n(rst_ni), .clr(acc_clr), .wr_en(cnt_we),
    .wr_idx(d_cnt[1:0]), .wr_byte(rd_data), .value(cnt_val));

  cpp_le_accum #(.NBYTES(4)) u_nent (
    .clk(clk), .rst_n(rst_ni), .clr(acc_clr), .wr_en(nent_we),
    .wr_idx(d_nent[1:0]), .wr_byte(rd_data), .value(nent_val));

  cpp_le_accum #(.NBYTES(8)) u_tbl (
    .clk(clk), .rst_n(rst_ni), .clr(acc_clr), .wr_en(tbl_we),
    .wr_idx(d_tbl[2:0]), .wr_byte(rd_data), .value(tbl_val));

  cpp_le_accum #(.NBYTES(8)) u_sga (
    .clk(clk), .rst_n(rst_ni), .clr(acc_clr), .wr_en(sga_we),
    .wr_idx(step_q[2:0]), .wr_byte(rd_data), .value(addr_val));

  cpp_le_accum #(.NBYTES(4)) u_sgl (
    .clk(clk), .rst_n(rst_ni), .clr(acc_clr), .wr_en(sgl_we),
    .wr_idx(step_q[1:0]), .wr_byte(rd_data), .value(len_val));

  cpp_hdr_check #(.ADDR_W(ADDR_W)) u_chk (
    .tag0(tag0_q), .hflags(hflags_q), .tag1(tag1_q),
    .nent(nent_val), .tbl(tbl_val), .fmt_err(fmt_err));

  cpp_len_tally #(.LEN_W(32), .SUM_W(64)) u_tally (
    .clk(clk), .rst_n(rst_ni), .clr(acc_clr), .add_en(tally_add),
    .add_len(len_val), .total(cnt_val), .sum(tally_sum), .match(tally_match));

  // read address
  always_comb begin
    case (state_q)
      S_HDR:   rd_addr = base_q + ADDR_W'(hdr_offset(step_q));
      S_SGRD:  rd_addr = ent_q + ADDR_W'(step_q);
      default: rd_addr = base_q;
    endcase
  end

  // next state
  always_comb begin
    state_n   = state_q;
    step_n    = step_q;
    base_n    = base_q;
    ent_n     = ent_q;
    remain_n  = remain_q;
    tag0_n    = tag0_q;
    hflags_n  = hflags_q;
    tag1_n    = tag1_q;
    dflags_n  = dflags_q;
    fmt_n     = fmt_q;
    status_n  = status_q;
    done_n    = 1'b0;
    hdrv_n    = 1'b0;
    acc_clr   = 1'b0;
    tally_add = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          state_n = S_HDR;
          step_n  = 5'd0;
          base_n  = pkt_base;
          fmt_n   = 1'b0;
          acc_clr = 1'b1;
        end
      end
      S_HDR: begin
        if (step_q == 5'd0)  tag0_n   = rd_data;
        if (step_q == 5'd1)  hflags_n = rd_data;
        if (step_q == 5'd18) tag1_n   = rd_data;
        if (step_q == 5'd19) dflags_n = rd_data;
        if (step_q == HDR_LAST) state_n = S_CHK;
        else                    step_n  = step_q + 5'd1;
      end
      S_CHK: begin
        if (fmt_err) begin
          fmt_n   = 1'b1;
          state_n = S_FIN;
        end else begin
          hdrv_n   = 1'b1;
          remain_n = nent_val;
          ent_n    = tbl_val[ADDR_W-1:0];
          step_n   = 5'd0;
          state_n  = S_SGRD;
        end
      end
      S_SGRD: begin
        if (step_q == ENT_LAST) state_n = S_SGOUT;
        else                    step_n  = step_q + 5'd1;
      end
      S_SGOUT: begin
        if (xfer_ready) begin
          tally_add = 1'b1;
          remain_n  = remain_q - 32'd1;
          ent_n     = ent_q + ADDR_W'(ENT_STRIDE);
          step_n    = 5'd0;
          state_n   = (remain_q == 32'd1) ? S_FIN : S_SGRD;
        end
      end
      S_FIN: begin
        done_n   = 1'b1;
        status_n = fmt_q ? ST_FMT : (tally_match ? ST_OK : ST_LEN);
        state_n  = S_IDLE;
      end
      default: state_n = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      step_q   <= 5'd0;
      base_q   <= '0;
      ent_q    <= '0;
      remain_q <= 32'd0;
      tag0_q   <= 8'h00;
      hflags_q <= 8'h00;
      tag1_q   <= 8'h00;
      dflags_q <= 8'h00;
      fmt_q    <= 1'b0;
      done_q   <= 1'b0;
      hdrv_q   <= 1'b0;
      status_q <= ST_OK;
    end else begin
      state_q  <= state_n;
      step_q   <= step_n;
      base_q   <= base_n;
      ent_q    <= ent_n;
      remain_q <= remain_n;
      tag0_q   <= tag0_n;
      hflags_q <= hflags_n;
      tag1_q   <= tag1_n;
      dflags_q <= dflags_n;
      fmt_q    <= fmt_n;
      done_q   <= done_n;
      hdrv_q   <= hdrv_n;
      status_q <= status_n;
    end
  end

  assign busy       = (state_q != S_IDLE);
  assign hdr_valid  = hdrv_q;
  assign dir_out    = hflags_q[HF_DIR];
  assign is_data    = hflags_q[HF_DATA];
  assign irq_en     = hflags_q[HF_IRQ];
  assign use_dma    = dflags_q[DF_DMA];
  assign lba48      = dflags_q[DF_LBA48];
  assign byte_cnt   = cnt_val;
  assign fis_addr   = base_q + ADDR_W'(FIS_OFS);
  assign xfer_valid = (state_q == S_SGOUT);
  assign xfer_addr  = addr_val;
  assign xfer_len   = len_val;
  assign done       = done_q;
  assign status     = status_q;

  // R1: nothing is offered while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |-> !xfer_valid);

  // R3: a format error never follows an accepted request
  p_fmt_silent_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (done && status == ST_FMT) |-> (tally_sum == 64'd0));

  // R7: a stalled request holds its payload
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (xfer_valid && !xfer_ready) |=>
      (xfer_valid && $stable(xfer_addr) && $stable(xfer_len)));

  // R8: an ok status only when the tally equals the byte count
  p_ok_match_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (done && status == ST_OK) |-> tally_match);

  // R10: done is a single pulse, raised with busy low, never an unused code
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> (!busy && status != 2'b11) ##1 !done);
endmodule

// File: tb/cpp_cmd_parser_tb.sv
module cpp_cmd_parser_tb_top;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] pkt_base;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          busy, hdr_valid, dir_out, is_data, irq_en, use_dma, lba48;
  logic [31:0]   byte_cnt;
  logic [AW-1:0] fis_addr;
  logic          xfer_valid, xfer_ready;
  logic [63:0]   xfer_addr;
  logic [31:0]   xfer_len;
  logic          done;
  logic [1:0]    status;

  logic [7:0] mem [1024];
  assign rd_data = mem[rd_addr[9:0]];

  int applied = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  cpp_cmd_parser #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pkt_base(pkt_base),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .hdr_valid(hdr_valid),
    .dir_out(dir_out), .is_data(is_data), .irq_en(irq_en), .use_dma(use_dma),
    .lba48(lba48), .byte_cnt(byte_cnt), .fis_addr(fis_addr),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
    .xfer_len(xfer_len), .done(done), .status(status));

  // vector: [31:24] host flags, [23:16] device flags, [15:12] entries,
  // [8] bad sum, [7] bad tag0, [6] bad tag1, [1:0] expected status
  localparam logic [31:0] VECS [7] = '{
    32'h390C_3000,   // R2 R6 R8 three entries, all flags set
    32'h3804_1000,   // R2 R8 one entry, read direction
    32'h2908_4102,   // R8 four entries, sum off by one -> length error
    32'h190C_2001,   // R3 valid flag clear
    32'h390C_2081,   // R3 bad tag at byte 0
    32'h390C_2041,   // R3 bad tag at byte 24
    32'h390C_0001    // R4 zero entries
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_le(input int a, input logic [63:0] v, input int n);
    for (int k = 0; k < n; k++) mem[(a + k) % 1024] = v[8*k +: 8];
  endtask

  function automatic logic [63:0] ent_addr(input int vid, input int i);
    return {32'hA500_0000 | 32'(vid), 32'(i * 32'h1_0000 + 32'h40)};
  endfunction

  function automatic logic [31:0] ent_len(input int i);
    return 32'(512 * (i + 1));
  endfunction

  task automatic run_pkt(input int vid, input int base, input int tbl,
                         input logic [7:0] hf, input logic [7:0] df, input int nent,
                         input bit badsum, input bit bt0, input bit bt1,
                         input bit hi_tbl, input bit extra_start,
                         input logic [1:0] exp_st);
    logic [31:0] total;
    logic [63:0] tbl64;
    int nx, nh, cyc;
    bit seen_done;
    total = 32'd0;
    for (int i = 0; i < nent; i++) total += ent_len(i);
    if (badsum) total += 32'd1;
    tbl64 = 64'(tbl);
    if (hi_tbl) tbl64[32] = 1'b1;
    for (int k = 0; k < 64; k++) mem[base + k] = 8'hCC;
    mem[base + 0]  = bt0 ? 8'h7E : 8'h01;
    mem[base + 1]  = hf;
    put_le(base + 4, 64'(total), 4);
    put_le(base + 8, 64'(nent), 4);
    put_le(base + 16, tbl64, 8);
    mem[base + 24] = bt1 ? 8'h20 : 8'h02;
    mem[base + 28] = df;
    for (int i = 0; i < nent; i++) begin
      put_le(tbl + 16 * i, ent_addr(vid, i), 8);
      put_le(tbl + 16 * i + 8, 64'(ent_len(i)), 4);
      put_le(tbl + 16 * i + 12, 64'hEEEE_EEEE, 4);
    end
    @(negedge clk);
    pkt_base = AW'(base);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nx = 0; nh = 0; seen_done = 0;
    for (cyc = 0; cyc < 3000 && !seen_done; cyc++) begin
      @(negedge clk);
      if (extra_start) begin
        start = (cyc == 4);
        pkt_base = AW'(base + 16);
      end
      xfer_ready = ((cyc % 3) != 1);
      if (hdr_valid) begin
        nh++;
        chk("R2 dir_out", 64'(dir_out), 64'(hf[0]));
        chk("R2 is_data", 64'(is_data), 64'(hf[3]));
        chk("R2 irq_en", 64'(irq_en), 64'(hf[4]));
        chk("R2 use_dma", 64'(use_dma), 64'(df[2]));
        chk("R2 lba48", 64'(lba48), 64'(df[3]));
        chk("R2 byte_cnt", 64'(byte_cnt), 64'(total));
        chk("R2 fis_addr", 64'(fis_addr), 64'(base + 32));
      end
      if (xfer_valid && xfer_ready) begin
        chk("R6 xfer_addr", xfer_addr, ent_addr(vid, nx));
        chk("R6 xfer_len", 64'(xfer_len), 64'(ent_len(nx)));
        nx++;
      end
      if (done) begin
        seen_done = 1;
        chk("R10 busy low at done", 64'(busy), 64'd0);
        chk("R3 R4 R5 R8 status", 64'(status), 64'(exp_st));
      end
    end
    start = 1'b0;
    xfer_ready = 1'b0;
    chk("R10 done seen", 64'(seen_done), 64'd1);
    chk("R3 R4 R5 R6 request count", 64'(nx), (exp_st == 2'b01) ? 64'd0 : 64'(nent));
    chk("R2 R3 hdr_valid count", 64'(nh), (exp_st == 2'b01) ? 64'd0 : 64'd1);
    if (extra_start) begin
      int extra = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (busy || done) extra++;
      end
      chk("R9 no second run", 64'(extra), 64'd0);
    end
    @(negedge clk);
    chk("R10 status held", 64'(status), 64'(exp_st));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    for (int k = 0; k < 1024; k++) mem[k] = 8'h00;
    rst_n = 1'b0;
    start = 1'b0;
    pkt_base = '0;
    xfer_ready = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 hdr_valid", 64'(hdr_valid), 64'd0);
    chk("R1 xfer_valid", 64'(xfer_valid), 64'd0);

    for (int v = 0; v < 7; v++) begin
      logic [31:0] w;
      w = VECS[v];
      run_pkt(v, v * 48, 512 + v * 64, w[31:24], w[23:16], int'(w[15:12]),
              w[8], w[7], w[6], 1'b0, 1'b0, w[1:0]);
    end

    // R5: table address above the address width
    run_pkt(7, 400, 960, 8'h39, 8'h0C, 2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01);
    // R9: second start while busy is ignored
    run_pkt(8, 0, 768, 8'h28, 8'h04, 3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00);
    // R8: length error after a single entry
    run_pkt(9, 128, 832, 8'h21, 8'h00, 1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10);

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule